// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt sources and reports them to a processor on two request lines: a normal request and a fast request. Software reaches it through a simple 32-bit register bus. For each source, software can enable it, force it active, give it a 4-bit priority and send it to either the fast or the normal path. The source number and priority of the winning request can then be read back from a vector/status word.

A source is enabled or disabled by writing its number to a dedicated port register, so no read-modify-write of a bit mask is needed. Direct access to the enable words is also available. Normal requests pass through a priority arbiter and a programmable mask threshold. Fast requests are not arbitrated by priority: the highest-numbered pending fast source is reported.

The register bus has no back-pressure. A write is taken on every clock edge where `bus_valid` and `bus_write` are both high. Read data is combinational from `bus_addr` while `bus_valid` is high and `bus_write` is low, and is zero otherwise. Both request outputs are plain registered levels with no handshake.

Top module: `vic_core`

## Requirements
- R1: After reset the control word, all enable, type, force and priority bits are 0, the mask word is 0x1F, both request outputs are 0, and both vector words read 0xFFFFFFFF.
- R2: Word offsets (byte address): control 0x00, mask 0x04, enable-number 0x08, disable-number 0x0C, enable 0x10/0x14, type 0x18/0x1C, source 0x48/0x4C, force 0x50/0x54, normal pending 0x58/0x5C, fast pending 0x60/0x64. In each pair the lower address holds sources 63..32 and the higher address holds sources 31..0, with source n at bit n mod 32. The source, pending and vector words are read-only. The number ports read 0.
- R3: Writing a value v below 64 to the enable-number port sets enable bit v and leaves the other 63 bits unchanged. A value of 64 or more changes nothing.
- R4: Writing a value v below 64 to the disable-number port clears enable bit v and leaves the others unchanged. A value of 64 or more changes nothing.
- R5: Source s has a 4-bit priority at byte address 0x20 + 4*(7 - s/8), in bits [(s mod 8)*4+3 : (s mod 8)*4].
- R6: A source is pending when (raw input OR force bit) AND enable bit is true. It is a normal pending source when its type bit is 0 and a fast pending source when its type bit is 1. The pending words show this state live.
- R7: Among normal pending sources, the one with the highest priority wins, and a tie goes to the higher source number. The normal vector word (0x40) returns the winner's number in bits [31:16] and its priority in bits [15:0].
- R8: The normal winner qualifies only when its priority is strictly greater than the 5-bit mask value. With no qualifying winner, the normal vector reads 0xFFFFFFFF and the normal request stays low. A mask of 0x1F therefore blocks every normal source.
- R9: The fast vector word (0x44) returns the highest-numbered fast pending source in bits [31:16], with bits [15:0] zero. It reads 0xFFFFFFFF when no fast source is pending.
- R10: The normal request is high exactly one clock after a cycle with a qualifying normal winner. The fast request is high exactly one clock after a cycle with any fast pending source. Neither output latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| src_in | input | 64 | Raw level of each interrupt source |
| norm_irq | output | 1 | Registered normal interrupt request |
| fast_irq | output | 1 | Registered fast interrupt request |

## Verification
The bench enables and then disables every source by number, and compares both enable words against a model after each write. A design that touched neighbouring bits, or that let out-of-range numbers alias onto low sources, would show up in those words. Each source is given in turn a distinct priority and is made the only active source. The vector must then report exactly that number and priority, which exposes a reversed or shifted priority group layout. The mask is swept through all 32 values against a fixed priority to catch an off-by-one between "greater" and "greater or equal". Equal-priority pairs and mixed fast/normal sets check the tie rule and the routing by type. The bench also checks that the request lines lag their cause by exactly one clock.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned WORD_W    = 5;   // word index = byte address >> 2
  localparam int unsigned N_SRC     = 64;
  localparam int unsigned PRIO_W    = 4;
  localparam int unsigned MASK_W    = 5;
  localparam int unsigned GRP_SIZE  = DATA_W / PRIO_W;
  localparam int unsigned N_GRP     = N_SRC / GRP_SIZE;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t W_CTRL   = 5'd0;
  localparam word_t W_MASK   = 5'd1;
  localparam word_t W_ENNUM  = 5'd2;
  localparam word_t W_DISNUM = 5'd3;
  localparam word_t W_ENH    = 5'd4;
  localparam word_t W_ENL    = 5'd5;
  localparam word_t W_TYH    = 5'd6;
  localparam word_t W_TYL    = 5'd7;
  localparam word_t W_PRI0   = 5'd8;   // holds the top group; group g at W_PRI0 + (N_GRP-1-g)
  localparam word_t W_NVEC   = 5'd16;
  localparam word_t W_FVEC   = 5'd17;
  localparam word_t W_SRCH   = 5'd18;
  localparam word_t W_SRCL   = 5'd19;
  localparam word_t W_FRCH   = 5'd20;
  localparam word_t W_FRCL   = 5'd21;
  localparam word_t W_NPH    = 5'd22;
  localparam word_t W_NPL    = 5'd23;
  localparam word_t W_FPH    = 5'd24;
  localparam word_t W_FPL    = 5'd25;

  localparam logic [DATA_W-1:0] NO_VECTOR = '1;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned NSRC  = N_SRC,
  parameter int unsigned PW    = PRIO_W,
  parameter int unsigned MW    = MASK_W,
  parameter int unsigned DW    = DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  word_t              wr_word,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      ctrl_q,
  output logic [MW-1:0]      mask_q,
  output logic [NSRC-1:0]    en_q,
  output logic [NSRC-1:0]    type_q,
  output logic [NSRC-1:0]    force_q,
  output logic [NSRC*PW-1:0] prio_q
);
  localparam int unsigned SW   = $clog2(NSRC);
  localparam int unsigned NGRP = (NSRC * PW) / DW;

  logic num_ok;
  logic [SW-1:0] num_idx;
  assign num_ok  = (wr_data < DW'(NSRC));
  assign num_idx = wr_data[SW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mask_q  <= '1;
      en_q    <= '0;
      type_q  <= '0;
      force_q <= '0;
    end else if (wr_en) begin
      case (wr_word)
        W_CTRL:   ctrl_q <= wr_data;
        W_MASK:   mask_q <= wr_data[MW-1:0];
        W_ENNUM:  if (num_ok) en_q[num_idx] <= 1'b1;
        W_DISNUM: if (num_ok) en_q[num_idx] <= 1'b0;
        W_ENH:    en_q[NSRC-1:DW]    <= wr_data;
        W_ENL:    en_q[DW-1:0]       <= wr_data;
        W_TYH:    type_q[NSRC-1:DW]  <= wr_data;
        W_TYL:    type_q[DW-1:0]     <= wr_data;
        W_FRCH:   force_q[NSRC-1:DW] <= wr_data;
        W_FRCL:   force_q[DW-1:0]    <= wr_data;
        default:  ;
      endcase
    end
  end

  // One storage word per priority group; the highest group sits at the lowest address.
  for (genvar g = 0; g < NGRP; g++) begin : g_prio
    localparam word_t MY_WORD = word_t'(int'(W_PRI0) + (NGRP - 1 - g));
    logic [DW-1:0] grp_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           grp_q <= '0;
      else if (wr_en && wr_word == MY_WORD) grp_q <= wr_data;
    end
    assign prio_q[g*DW +: DW] = grp_q;
  end
endmodule

// File: rtl/vic_norm_arb.sv
module vic_norm_arb #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned PW   = 4,
  parameter int unsigned MW   = 5
) (
  input  logic [NSRC-1:0]         pend,
  input  logic [NSRC*PW-1:0]      prio,
  input  logic [MW-1:0]           mask,
  output logic                    win_valid,
  output logic [$clog2(NSRC)-1:0] win_id,
  output logic [PW-1:0]           win_prio
);
  localparam int unsigned SW = $clog2(NSRC);

  logic          any;
  logic [SW-1:0] best_id;
  logic [PW-1:0] best_p;

  // Ascending scan with >= so that equal priorities resolve to the higher number.
  always_comb begin
    any     = 1'b0;
    best_id = '0;
    best_p  = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (pend[s] && (!any || prio[s*PW +: PW] >= best_p)) begin
        any     = 1'b1;
        best_id = SW'(s);
        best_p  = prio[s*PW +: PW];
      end
    end
  end

  assign win_valid = any && (int'(best_p) > int'(mask));
  assign win_id    = best_id;
  assign win_prio  = best_p;
endmodule

// File: rtl/vic_fast_arb.sv
module vic_fast_arb #(
  parameter int unsigned NSRC = 64
) (
  input  logic [NSRC-1:0]         pend,
  output logic                    win_valid,
  output logic [$clog2(NSRC)-1:0] win_id
);
  localparam int unsigned SW = $clog2(NSRC);

  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (pend[s]) begin
        win_valid = 1'b1;
        win_id    = SW'(s);
      end
    end
  end
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [6:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  src_in,
  output logic              norm_irq,
  output logic              fast_irq
);
  localparam int unsigned SW = $clog2(N_SRC);
  localparam int unsigned HW = DATA_W / 2;

  word_t word;
  assign word = bus_addr[6:2];

  logic [DATA_W-1:0]       ctrl_q;
  logic [MASK_W-1:0]       mask_q;
  logic [N_SRC-1:0]        en_q, type_q, force_q;
  logic [N_SRC*PRIO_W-1:0] prio_q;

  vic_regs #(.NSRC(N_SRC), .PW(PRIO_W), .MW(MASK_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_valid && bus_write), .wr_word(word), .wr_data(bus_wdata),
    .ctrl_q(ctrl_q), .mask_q(mask_q), .en_q(en_q), .type_q(type_q),
    .force_q(force_q), .prio_q(prio_q)
  );

  logic [N_SRC-1:0] pend, norm_pend, fast_pend;
  assign pend      = (src_in | force_q) & en_q;
  assign norm_pend = pend & ~type_q;
  assign fast_pend = pend & type_q;

  logic              n_valid, f_valid;
  logic [SW-1:0]     n_id, f_id;
  logic [PRIO_W-1:0] n_prio;

  vic_norm_arb #(.NSRC(N_SRC), .PW(PRIO_W), .MW(MASK_W)) u_narb (
    .pend(norm_pend), .prio(prio_q), .mask(mask_q),
    .win_valid(n_valid), .win_id(n_id), .win_prio(n_prio)
  );

  vic_fast_arb #(.NSRC(N_SRC)) u_farb (
    .pend(fast_pend), .win_valid(f_valid), .win_id(f_id)
  );

  logic [DATA_W-1:0] nvec, fvec;
  assign nvec = n_valid ? {HW'(n_id), HW'(n_prio)} : NO_VECTOR;
  assign fvec = f_valid ? {HW'(f_id), {HW{1'b0}}}  : NO_VECTOR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      norm_irq <= 1'b0;
      fast_irq <= 1'b0;
    end else begin
      norm_irq <= n_valid;
      fast_irq <= f_valid;
    end
  end

  logic [DATA_W-1:0] rmux;
  always_comb begin
    rmux = '0;
    case (word)
      W_CTRL: rmux = ctrl_q;
      W_MASK: rmux = DATA_W'(mask_q);
      W_ENH:  rmux = en_q[N_SRC-1:DATA_W];
      W_ENL:  rmux = en_q[DATA_W-1:0];
      W_TYH:  rmux = type_q[N_SRC-1:DATA_W];
      W_TYL:  rmux = type_q[DATA_W-1:0];
      W_NVEC: rmux = nvec;
      W_FVEC: rmux = fvec;
      W_SRCH: rmux = src_in[N_SRC-1:DATA_W];
      W_SRCL: rmux = src_in[DATA_W-1:0];
      W_FRCH: rmux = force_q[N_SRC-1:DATA_W];
      W_FRCL: rmux = force_q[DATA_W-1:0];
      W_NPH:  rmux = norm_pend[N_SRC-1:DATA_W];
      W_NPL:  rmux = norm_pend[DATA_W-1:0];
      W_FPH:  rmux = fast_pend[N_SRC-1:DATA_W];
      W_FPL:  rmux = fast_pend[DATA_W-1:0];
      default: begin
        if (word >= W_PRI0 && int'(word) < int'(W_PRI0) + N_GRP)
          rmux = prio_q[(int'(W_PRI0) + N_GRP - 1 - int'(word)) * DATA_W +: DATA_W];
      end
    endcase
  end

  assign bus_rdata = (bus_valid && !bus_write) ? rmux : '0;
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk
  import vic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [6:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_SRC-1:0]  en_q,
  input logic [MASK_W-1:0] mask_q,
  input logic              n_valid,
  input logic              f_valid,
  input logic [N_SRC-1:0]  fast_pend,
  input logic              norm_irq,
  input logic              fast_irq
);
  logic wr_ennum, wr_disnum;
  assign wr_ennum  = bus_valid && bus_write && bus_addr[6:2] == W_ENNUM;
  assign wr_disnum = bus_valid && bus_write && bus_addr[6:2] == W_DISNUM;

  // R3
  enable_by_number_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ennum && bus_wdata < 32'd64) |=> en_q == ($past(en_q) | (64'd1 << $past(bus_wdata[5:0]))));

  // R4
  disable_by_number_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_disnum && bus_wdata < 32'd64) |=> en_q == ($past(en_q) & ~(64'd1 << $past(bus_wdata[5:0]))));

  // R3
  enable_number_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_ennum || wr_disnum) && bus_wdata >= 32'd64) |=> $stable(en_q));

  // R8
  full_mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 5'h1F) |=> !norm_irq);

  // R10
  norm_irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> norm_irq == $past(n_valid));

  // R10
  fast_irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fast_irq == $past(fast_pend != '0));

  // R9
  fast_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_valid == (fast_pend != '0));
endmodule

bind vic_core vic_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .en_q(en_q), .mask_q(mask_q),
  .n_valid(n_valid), .f_valid(f_valid), .fast_pend(fast_pend),
  .norm_irq(norm_irq), .fast_irq(fast_irq)
);

// File: tb/vic_core_bench.sv
module vic_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        norm_irq, fast_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_core u_vic_core (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .norm_irq(norm_irq), .fast_irq(fast_irq)
  );

  // Bench-side model of programmed state
  logic [63:0] m_en, m_ty, m_frc;
  logic [3:0]  m_pr [64];
  logic [4:0]  m_mask;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_nvec();
    logic [63:0] p;
    int best;
    p = (src_in | m_frc) & m_en & ~m_ty;
    best = -1;
    for (int s = 0; s < 64; s++)
      if (p[s] && (best < 0 || m_pr[s] >= m_pr[best])) best = s;
    if (best < 0 || int'(m_pr[best]) <= int'(m_mask)) return 32'hFFFF_FFFF;
    return {16'(best), 12'd0, m_pr[best]};
  endfunction

  function automatic logic [31:0] exp_fvec();
    logic [63:0] p;
    p = (src_in | m_frc) & m_en & m_ty;
    for (int s = 63; s >= 0; s--) if (p[s]) return {16'(s), 16'd0};
    return 32'hFFFF_FFFF;
  endfunction

  task automatic wr_prio_all();
    for (int g = 0; g < 8; g++) begin
      logic [31:0] w;
      for (int k = 0; k < 8; k++) w[k*4 +: 4] = m_pr[g*8+k];
      wr(7'(32'h20 + 4*(7-g)), w);
    end
  endtask

  task automatic check_outputs(string req);
    logic [31:0] d;
    rd(7'h40, d); chk({req, " nvec"}, d, exp_nvec());
    rd(7'h44, d); chk({req, " fvec"}, d, exp_fvec());
    tick();
    chk({req, " norm_irq"}, {31'd0, norm_irq}, {31'd0, exp_nvec() != 32'hFFFF_FFFF});
    chk({req, " fast_irq"}, {31'd0, fast_irq}, {31'd0, exp_fvec() != 32'hFFFF_FFFF});
  endtask

  initial begin : wdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable wdog;
    end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    m_en = '0; m_ty = '0; m_frc = '0; m_mask = 5'h1F;
    for (int s = 0; s < 64; s++) m_pr[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    rd(7'h00, d); chk("R1 ctrl", d, 32'h0);
    rd(7'h04, d); chk("R1 mask", d, 32'h1F);
    rd(7'h10, d); chk("R1 enh", d, 32'h0);
    rd(7'h14, d); chk("R1 enl", d, 32'h0);
    rd(7'h18, d); chk("R1 tyh", d, 32'h0);
    rd(7'h1C, d); chk("R1 tyl", d, 32'h0);
    for (int a = 8'h20; a <= 8'h3C; a += 4) begin rd(7'(a), d); chk("R1 prio", d, 32'h0); end
    rd(7'h40, d); chk("R1 nvec", d, 32'hFFFF_FFFF);
    rd(7'h44, d); chk("R1 fvec", d, 32'hFFFF_FFFF);
    chk("R1 irqs", {30'd0, norm_irq, fast_irq}, 32'd0);

    // R2: pair layout and control word
    wr(7'h00, 32'hA5A5_0001); rd(7'h00, d); chk("R2 ctrl", d, 32'hA5A5_0001);
    wr(7'h10, 32'h8000_0001); wr(7'h14, 32'h0000_0003);
    rd(7'h10, d); chk("R2 enh", d, 32'h8000_0001);
    rd(7'h14, d); chk("R2 enl", d, 32'h0000_0003);
    src_in = 64'h0000_0004_8000_0000;
    rd(7'h48, d); chk("R2 srch", d, 32'h0000_0004);
    rd(7'h4C, d); chk("R2 srcl", d, 32'h8000_0000);
    src_in = '0;
    wr(7'h10, 0); wr(7'h14, 0);

    // R3: enable every source by number, plus out-of-range values
    for (int s = 0; s < 64; s++) begin
      wr(7'h08, 32'(s)); m_en[s] = 1'b1;
      rd(7'h10, d); chk("R3 enh", d, m_en[63:32]);
      rd(7'h14, d); chk("R3 enl", d, m_en[31:0]);
    end
    wr(7'h0C, 32'd5); m_en[5] = 1'b0;
    wr(7'h08, 32'd69); wr(7'h08, 32'h100);
    rd(7'h14, d); chk("R3 out-of-range enl", d, m_en[31:0]);
    // R4: disable every source by number, plus out-of-range values
    wr(7'h0C, 32'd64); wr(7'h0C, 32'hFFFF_FFFF);
    rd(7'h10, d); chk("R4 out-of-range enh", d, m_en[63:32]);
    for (int s = 63; s >= 0; s--) begin
      wr(7'h0C, 32'(s)); m_en[s] = 1'b0;
      rd(7'h10, d); chk("R4 enh", d, m_en[63:32]);
      rd(7'h14, d); chk("R4 enl", d, m_en[31:0]);
    end

    // R5/R7: each source alone with a distinct priority reports itself
    for (int s = 0; s < 64; s++) m_pr[s] = 4'(1 + (s*7) % 15);
    wr_prio_all();
    wr(7'h04, 0); m_mask = 0;
    rd(7'h38, d); chk("R5 group1 word", d,
      {m_pr[15],m_pr[14],m_pr[13],m_pr[12],m_pr[11],m_pr[10],m_pr[9],m_pr[8]});
    for (int s = 0; s < 64; s++) begin
      wr(7'h08, 32'(s)); m_en[s] = 1'b1;
      src_in = 64'd1 << s;
      rd(7'h40, d); chk("R5 single source vector", d, {16'(s), 12'd0, m_pr[s]});
      wr(7'h0C, 32'(s)); m_en[s] = 1'b0;
    end
    src_in = '0;

    // R7: ties go to the higher number; higher priority beats higher number
    m_en = '1; wr(7'h10, 32'hFFFF_FFFF); wr(7'h14, 32'hFFFF_FFFF);
    for (int s = 0; s < 64; s++) m_pr[s] = 4'd3;
    m_pr[10] = 4'd9; m_pr[40] = 4'd9; m_pr[50] = 4'd7;
    wr_prio_all();
    src_in = (64'd1 << 10) | (64'd1 << 40) | (64'd1 << 50) | (64'd1 << 2);
    check_outputs("R7 tie");
    src_in = (64'd1 << 10) | (64'd1 << 50);
    check_outputs("R7 priority over number");
    src_in = 64'hFFFF_FFFF_FFFF_FFFF;
    check_outputs("R7 all active");

    // R8: mask sweep against a single source of priority 9
    src_in = 64'd1 << 10;
    for (int m = 0; m < 32; m++) begin
      wr(7'h04, 32'(m)); m_mask = 5'(m);
      check_outputs("R8 mask sweep");
    end

    // R6/R9: type routing, force, pending words
    wr(7'h04, 0); m_mask = 0;
    m_ty = 64'h0000_0100_0000_0010;
    wr(7'h18, m_ty[63:32]); wr(7'h1C, m_ty[31:0]);
    src_in = 64'h0000_0100_0000_0010 | (64'd1 << 20);
    rd(7'h60, d); chk("R6 fast pend high", d, 32'h0000_0100);
    rd(7'h64, d); chk("R6 fast pend low",  d, 32'h0000_0010);
    rd(7'h5C, d); chk("R6 norm pend low",  d, 32'h0010_0000);
    check_outputs("R9 mixed");
    src_in = 64'd1 << 4;
    check_outputs("R9 only low fast");
    src_in = '0;
    m_frc = 64'd1 << 33;
    wr(7'h50, m_frc[63:32]);
    rd(7'h58, d); chk("R6 forced norm pend", d, 32'h0000_0002);
    check_outputs("R6 force");
    wr(7'h0C, 32'd33); m_en[33] = 1'b0;
    check_outputs("R6 force while disabled");
    rd(7'h58, d); chk("R6 disabled pend", d, 32'h0);

    // R10: one-cycle lag, no latching
    tick();
    src_in = 64'd1 << 4;
    #1 chk("R10 fast before edge", {31'd0, fast_irq}, 32'd0);
    tick(); chk("R10 fast after edge", {31'd0, fast_irq}, 32'd1);
    src_in = '0;
    #1 chk("R10 fast holds until edge", {31'd0, fast_irq}, 32'd1);
    tick(); chk("R10 fast drops", {31'd0, fast_irq}, 32'd0);
    src_in = 64'd1 << 10;
    tick(); chk("R10 norm after edge", {31'd0, norm_irq}, 32'd1);
    src_in = '0;
    tick(); chk("R10 norm drops", {31'd0, norm_irq}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule